// File: doc/BRIEF.md
# Compact Nine-Bit Serial Port

This block is a very small asynchronous serial port meant for FPGA fabric. A host reaches it through a 16-bit register interface with two locations: address 0 is a status and control word and address 1 is the data word. Reads of the data word return the last received character. Writes to the data word queue a character for sending. The port has one transmitter and one receiver. Each frame carries 8 data bits, or 9 when the nine-bit option is set, then one stop bit. There is no hardware parity. The raw ninth bit lets software send and check its own even or odd parity.

A 3-bit speed field picks one of seven fixed rates, derived from the parameter `CLK_HZ`. The eighth setting of that field turns the port off. One level interrupt is raised in two cases: a received character is waiting, or the transmitter has just gone idle. The transmit-idle cause is cleared by any register read. Flow control is minimal. The transmitter begins a frame only while `cts` is high, and `rts` follows a register bit.

Both serial engines are state machines with the states IDLE, START, DATA and STOP. The transmitter moves IDLE→START when it accepts the holding buffer. It moves START→DATA after one bit time, DATA→DATA for each bit, DATA→STOP after the last data bit, and STOP→IDLE after the stop bit. The receiver moves IDLE→START on a low line. In START it checks the line at mid-bit: START→DATA if the line is still low, START→IDLE if it is not (glitch rejection). It moves DATA→STOP after the last mid-bit sample, and STOP→IDLE after sampling the stop bit.

Top module: `uart9_core`

## Requirements
- R1: After reset the status word reads with bit 0 = 1 and bits 1, 2 and 4 = 0, speed field = 0, nine-bit = 0, bits 15:9 = 0, and bit 3 equal to `cts`. `txd` is 1, `irq` is 0 and `rts` is 0.
- R2: The status word layout is as follows. Bit 0 = transmit buffer empty. Bit 1 = receive data ready. Bit 2 = overrun. Bit 3 = `cts`. Bit 4 = RTS, which is writable. Bits 7:5 = speed field, which is writable. Bit 8 = nine-bit enable, which is writable. Bits 15:9 read 0 and ignore writes. The `rts` pin equals bit 4.
- R3: One bit time is 16·max(1, floor(`CLK_HZ`/(16·rate))) clock cycles. The rate for speed values 0..6 is 115200, 57600, 38400, 19200, 9600, 4800 and 2400 baud.
- R4: A transmitted frame is a start bit of 0, then data bits LSB first, then a stop bit of 1. There are 8 data bits (bits 7:0 of the written word) or 9 when nine-bit is set. `txd` idles at 1.
- R5: Writing address 1 while the buffer is empty loads bits 8:0 and clears status bit 0. A write while the buffer is full is ignored. Bit 0 returns to 1 once the transmitter takes the character.
- R6: No frame starts while `cts` is 0. A loaded character waits until `cts` is 1.
- R7: A received frame places its data in bits 8:0 of address 1 and sets status bit 1. In 8-bit mode bit 8 reads 0, and bits 15:9 read 0. Reading address 1 clears status bit 1.
- R8: A low pulse on `rxd` shorter than half a bit time is not taken as a start bit and sets no flag.
- R9: A frame that completes while status bit 1 is set overwrites the buffer and sets status bit 2. A status read returns the set bit and clears it.
- R10: `irq` is 1 while status bit 1 is set.
- R11: When the transmitter goes from busy (buffer full or frame in progress) to idle, `irq` becomes 1. A read of either address clears that cause.
- R12: With speed field 7 the port is off. No frame is sent, no frame is received, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status/control, 1 = data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when not selected) |
| irq | output | 1 | Interrupt request, active high |
| cts | input | 1 | Clear-to-send, high permits transmission |
| rts | output | 1 | Request-to-send, mirrors status bit 4 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
A transmit state or bit counter that is off by one shows at `txd` within one frame. The bench reads the line at each expected mid-bit, so a missing, extra or shifted bit appears as a wrong captured character or a wrong stop bit. A wrong receive phase or mis-rejected start bit shows in the data word and the ready flag one frame after the stimulus. Flag bookkeeping errors show in `irq` and in the status word within a single register access. These include overrun, ready and transmit-done not set or not cleared.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } frame_st_t;

    localparam logic [2:0] MODE_OFF = 3'd7;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned TOP_RATE = 115200;

    // Prescale count for one oversampling tick at a given speed setting
    function automatic int unsigned step_div(int unsigned clk_hz, logic [2:0] mode);
        int unsigned slow;
        int unsigned d;
        case (mode)
            3'd0:    slow = 1;
            3'd1:    slow = 2;
            3'd2:    slow = 3;
            3'd3:    slow = 6;
            3'd4:    slow = 12;
            3'd5:    slow = 24;
            default: slow = 48;
        endcase
        d = clk_hz / (OVERSAMPLE * (TOP_RATE / slow));
        return (d == 0) ? 1 : d;
    endfunction

endpackage

// File: rtl/uart9_baud.sv
module uart9_baud
    import uart9_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    output logic       tick
);
    localparam int unsigned MAXDIV = step_div(CLK_HZ, 3'd6);
    localparam int unsigned CW = $clog2(MAXDIV + 1);

    logic [CW-1:0] div_tab [8];
    logic [CW-1:0] cnt;

    for (genvar g = 0; g < 8; g++) begin : g_tab
        assign div_tab[g] = CW'(step_div(CLK_HZ, 3'(g)) - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_OFF) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div_tab[mode]) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       go,
    input  logic       nine,
    input  logic [8:0] data,
    output logic       txd,
    output logic       busy
);
    frame_st_t st, nxt;
    logic [3:0] cnt;
    logic [3:0] idx;
    logic [3:0] last;
    logic [8:0] sh;
    logic       bit_end;

    assign bit_end = tick && (cnt == 4'd15);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st   <= S_IDLE;
            cnt  <= '0;
            idx  <= '0;
            last <= 4'd7;
            sh   <= '0;
        end else begin
            st <= nxt;
            if (st == S_IDLE) begin
                if (go) begin
                    sh   <= data;
                    last <= nine ? 4'd8 : 4'd7;
                    cnt  <= '0;
                    idx  <= '0;
                end
            end else if (tick) begin
                cnt <= cnt + 1'b1;
                if (st == S_DATA && cnt == 4'd15) begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (go) nxt = S_START;
            S_START: if (bit_end) nxt = S_DATA;
            S_DATA:  if (bit_end && idx == last) nxt = S_STOP;
            S_STOP:  if (bit_end) nxt = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            S_IDLE:  txd = 1'b1;
            S_START: txd = 1'b0;
            S_DATA:  txd = sh[idx];
            S_STOP:  txd = 1'b1;
        endcase
        busy = (st != S_IDLE);
    end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       nine,
    input  logic       rxd,
    output logic       valid,
    output logic [8:0] data
);
    frame_st_t st, nxt;
    logic [1:0] sync;
    logic       rx_s;
    logic [3:0] cnt;
    logic [3:0] idx;
    logic [3:0] last;
    logic [8:0] sh;

    assign rx_s = sync[1];
    assign last = nine ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= 2'b11;
        end else begin
            sync <= {sync[0], rxd};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st    <= S_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            st    <= nxt;
            valid <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                    sh  <= '0;
                end
                S_START: if (tick) cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 1'b1;
                S_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == 4'd15) begin
                        sh[idx] <= rx_s;
                        idx     <= idx + 1'b1;
                    end
                end
                S_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == 4'd15 && rx_s) begin
                        valid <= 1'b1;
                        data  <= sh;
                    end
                end
            endcase
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (!rx_s) nxt = S_START;
            S_START: if (tick && cnt == 4'd7) nxt = rx_s ? S_IDLE : S_DATA;
            S_DATA:  if (tick && cnt == 4'd15 && idx == last) nxt = S_STOP;
            S_STOP:  if (tick && cnt == 4'd15) nxt = S_IDLE;
        endcase
    end

    // R8: a frame is only ever delivered from the stop state
    a_r8_deliver_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(st) == S_STOP);
endmodule

// File: rtl/uart9_core.sv
module uart9_core
    import uart9_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_cs,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    input  logic        cts,
    output logic        rts,
    input  logic        rxd,
    output logic        txd
);
    logic       rts_q, nine_q;
    logic [2:0] mode_q;
    logic       en;
    logic       tick;
    logic [1:0] cts_sync;
    logic       cts_s;
    logic       hold_valid;
    logic [8:0] hold_data;
    logic       tx_go, tx_busy, tx_active, active_q, txdone;
    logic       rx_valid, rx_ready, ovr;
    logic [8:0] rx_word, rx_buf;
    logic       rd_stat, rd_data, wr_stat, wr_data, rd_any;

    assign rd_stat = bus_cs && !bus_wr && !bus_addr;
    assign rd_data = bus_cs && !bus_wr && bus_addr;
    assign wr_stat = bus_cs && bus_wr && !bus_addr;
    assign wr_data = bus_cs && bus_wr && bus_addr;
    assign rd_any  = rd_stat || rd_data;
    assign en      = (mode_q != MODE_OFF);
    assign cts_s   = cts_sync[1];
    assign rts     = rts_q;

    uart9_baud #(.CLK_HZ(CLK_HZ)) u_baud (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick)
    );

    uart9_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .go(tx_go),
        .nine(nine_q), .data(hold_data), .txd(txd), .busy(tx_busy)
    );

    uart9_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .nine(nine_q),
        .rxd(rxd), .valid(rx_valid), .data(rx_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_sync <= 2'b00;
        end else begin
            cts_sync <= {cts_sync[0], cts};
        end
    end

    // control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_q  <= 1'b0;
            mode_q <= 3'd0;
            nine_q <= 1'b0;
        end else if (wr_stat) begin
            rts_q  <= bus_wdata[4];
            mode_q <= bus_wdata[7:5];
            nine_q <= bus_wdata[8];
        end
    end

    // transmit holding buffer
    assign tx_go     = hold_valid && cts_s && en && !tx_busy;
    assign tx_active = hold_valid || tx_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (tx_go) begin
            hold_valid <= 1'b0;
        end else if (wr_data && !hold_valid) begin
            hold_valid <= 1'b1;
            hold_data  <= bus_wdata[8:0];
        end
    end

    // transmit-done cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            txdone   <= 1'b0;
        end else begin
            active_q <= tx_active;
            if (active_q && !tx_active) begin
                txdone <= 1'b1;
            end else if (rd_any) begin
                txdone <= 1'b0;
            end
        end
    end

    // receive buffer and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0;
            rx_buf   <= '0;
            ovr      <= 1'b0;
        end else begin
            if (rx_valid) begin
                rx_buf   <= rx_word;
                rx_ready <= 1'b1;
            end else if (rd_data) begin
                rx_ready <= 1'b0;
            end
            if (rx_valid && rx_ready && !rd_data) begin
                ovr <= 1'b1;
            end else if (rd_stat) begin
                ovr <= 1'b0;
            end
        end
    end

    assign irq = en && (rx_ready || txdone);

    always_comb begin
        bus_rdata = '0;
        if (rd_stat) begin
            bus_rdata = {7'd0, nine_q, mode_q, rts_q, cts_s, ovr, rx_ready, !hold_valid};
        end else if (rd_data) begin
            bus_rdata = {7'd0, rx_buf};
        end
    end

    // R6: a frame may only begin after CTS was seen high
    a_r6_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(cts_s));

    // R12: the line stays idle while the port is switched off
    a_r12_off_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> txd);

    // R9: a completed frame while data is waiting flags overrun
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !rd_data) |=> ovr);

    // R7: reading the data word drops the ready flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !rx_ready);

    // R5: a write into a full buffer leaves the held character alone
    a_r5_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && wr_data && !tx_go) |=> $stable(hold_data));

    // R11: the transmitter going idle raises the interrupt
    a_r11_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !tx_active && en) |=> (irq || mode_q == MODE_OFF));
endmodule

// File: tb/sim_uart9_core.sv
module sim_uart9_core;
    localparam int unsigned CLK_HZ = 3_686_400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, rts, txd;
    logic        cts = 1'b1, rxd = 1'b1;

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart9_core #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cts(cts), .rts(rts), .rxd(rxd), .txd(txd)
    );

    // vectors: {mode[2:0], nine, data[8:0]}
    localparam logic [12:0] VEC [6] = '{
        {3'd0, 1'b0, 9'h0A5},
        {3'd0, 1'b1, 9'h1C3},
        {3'd1, 1'b0, 9'h03C},
        {3'd2, 1'b1, 9'h100},
        {3'd3, 1'b0, 9'h0FF},
        {3'd1, 1'b1, 9'h155}
    };

    function automatic int bitc(input int mode);
        int slow;
        int d;
        slow = (mode == 0) ? 1 : (mode == 1) ? 2 : (mode == 2) ? 3 :
               (mode == 3) ? 6 : (mode == 4) ? 12 : (mode == 5) ? 24 : 48;
        d = CLK_HZ / (16 * (115200 / slow));
        if (d == 0) d = 1;
        return 16 * d;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic a, output logic [15:0] v);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic bus_wrt(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic capture(input int bc, input bit nine, output logic [8:0] d, output bit ok);
        int n;
        logic st, sp;
        n = 0;
        d = '0;
        ok = 0;
        while (txd && n < bc * 20) begin
            @(negedge clk);
            n++;
        end
        if (txd) return;
        repeat (bc / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            repeat (bc) @(negedge clk);
            d[i] = txd;
        end
        repeat (bc) @(negedge clk);
        sp = txd;
        ok = (st == 1'b0) && (sp == 1'b1);
    endtask

    task automatic send_rx(input int bc, input bit nine, input logic [8:0] d);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rxd = d[i];
            repeat (bc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic watch_quiet(input int cycles, output bit quiet);
        quiet = 1;
        repeat (cycles) begin
            @(negedge clk);
            if (!txd) quiet = 0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [8:0]  got;
        bit          ok;
        bit          quiet;
        int          bc;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        bus_rd(1'b0, v);
        check(v == 16'h0009, "R1 status", v, 16'h0009);
        check(txd == 1'b1 && irq == 1'b0 && rts == 1'b0, "R1 pins",
              {txd, irq, rts}, 3'b100);

        // R2 layout, reserved bits, rts pin
        bus_wrt(1'b0, 16'hFE1F);
        bus_rd(1'b0, v);
        check(v == 16'h0019, "R2 readback", v, 16'h0019);
        check(rts == 1'b1, "R2 rts pin", rts, 1);
        bus_wrt(1'b0, 16'h01C0);
        bus_rd(1'b0, v);
        check(v == 16'h01C9, "R2 fields", v, 16'h01C9);
        check(rts == 1'b0, "R2 rts low", rts, 0);

        // vector walk: R3 R4 transmit, R11 done irq, R7 R10 receive
        foreach (VEC[k]) begin
            logic [2:0] m;
            logic       nn;
            logic [8:0] dd;
            logic [8:0] expd;
            m  = VEC[k][12:10];
            nn = VEC[k][9];
            dd = VEC[k][8:0];
            bc = bitc(m);
            expd = nn ? dd : {1'b0, dd[7:0]};
            bus_wrt(1'b0, {7'd0, nn, m, 1'b1, 4'd0});
            bus_wrt(1'b1, {7'd0, dd});
            capture(bc, nn, got, ok);
            check(ok, "R4 framing", ok, 1);
            check(got == expd, "R3 R4 tx data", got, expd);
            repeat (bc) @(negedge clk);
            check(irq == 1'b1, "R11 done irq", irq, 1);
            bus_rd(1'b0, v);
            check(irq == 1'b0, "R11 read clears", irq, 0);
            send_rx(bc, nn, dd);
            check(irq == 1'b1, "R10 irq on ready", irq, 1);
            bus_rd(1'b0, v);
            check(v[1] == 1'b1 && v[2] == 1'b0, "R7 ready", v[2:1], 2'b01);
            bus_rd(1'b1, v);
            check(v == {7'd0, expd}, "R7 rx data", v, {7'd0, expd});
            bus_rd(1'b0, v);
            check(v[1] == 1'b0 && irq == 1'b0, "R7 ready cleared", {v[1], irq}, 0);
        end

        // R5 R6: hold while cts low, second write ignored
        bus_wrt(1'b0, 16'h0000);
        bc = bitc(0);
        cts = 1'b0;
        repeat (4) @(negedge clk);
        bus_wrt(1'b1, 16'h005A);
        bus_rd(1'b0, v);
        check(v[0] == 1'b0, "R5 empty cleared", v[0], 0);
        bus_wrt(1'b1, 16'h00C3);
        watch_quiet(bc * 3, quiet);
        check(quiet, "R6 no start without cts", quiet, 1);
        cts = 1'b1;
        capture(bc, 1'b0, got, ok);
        check(ok && got == 9'h05A, "R5 full write ignored", got, 9'h05A);
        bus_rd(1'b0, v);
        check(v[0] == 1'b1, "R5 empty again", v[0], 1);
        repeat (bc) @(negedge clk);
        bus_rd(1'b0, v);

        // R9 overrun
        send_rx(bc, 1'b0, 9'h011);
        send_rx(bc, 1'b0, 9'h022);
        bus_rd(1'b0, v);
        check(v[2:1] == 2'b11, "R9 overrun set", v[2:1], 2'b11);
        bus_rd(1'b1, v);
        check(v == 16'h0022, "R9 overwrite", v, 16'h0022);
        bus_rd(1'b0, v);
        check(v[2:1] == 2'b00, "R9 overrun cleared", v[2:1], 0);

        // R8 glitch rejection
        @(negedge clk);
        rxd = 1'b0;
        repeat (bc / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (bc * 12) @(negedge clk);
        bus_rd(1'b0, v);
        check(v[1] == 1'b0 && irq == 1'b0, "R8 glitch ignored", {v[1], irq}, 0);

        // R12 off
        bus_wrt(1'b0, 16'h00E0);
        bus_wrt(1'b1, 16'h0077);
        send_rx(bitc(0), 1'b0, 9'h033);
        watch_quiet(bitc(0) * 4, quiet);
        check(quiet, "R12 no tx when off", quiet, 1);
        check(irq == 1'b0, "R12 irq off", irq, 0);
        bus_rd(1'b0, v);
        check(v[1] == 1'b0, "R12 no rx when off", v[1], 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule